// File: doc/BRIEF.md
# Timed Analog Run-Mode Sequencer

This block steps an analog compute unit through one timed control cycle. Out of reset it waits in IDLE. A start pulse comes from a serial word detector. That detector watches a data line on the rising edges of an external sync clock. On a start, the block holds the unit in initial-condition mode (IC) for a programmed time, then in operate mode (OP) for a second programmed time, and then stops in END. END persists until reset. Both times are given in nanoseconds. An internal timer adds the clock period (`TICK_NS`) once per cycle, so a phase lasts ceil(duration / `TICK_NS`) cycles.

Two policy inputs decide what happens during OP:
- An overload flag can be ignored, or it can send the block to a latched OVERLOAD state.
- An external halt request can be ignored, or it can pause operation in a PAUSE state. The operate timer is frozen in PAUSE, and OP resumes when the request is released.

The durations and both policies are captured at the moment the block leaves IDLE. A duration outside 100 ns to 9,000,000,000 ns raises a configuration-error flag and blocks the start.

The sync clock, the sync data, the overload flag and the halt request are all resampled through two flops in the system clock domain. Each half-period of the sync clock must therefore last at least two system clock cycles.

State transitions:
- IDLE→IC on a start with a valid configuration.
- IC→OP on IC timer expiry.
- OP→OVERLOAD on overload under the latching policy.
- OP→PAUSE on a halt request under the pausing policy.
- OP→END on OP timer expiry.
- PAUSE→OP on release of the halt request.
- END and OVERLOAD are held until reset.

Top module: `run_sequencer`

## Requirements
- R1: After reset the block is in IDLE: `state_code`=0, `mode_halt`=1, `mode_ic`=0 and `mode_op`=0. It leaves IDLE only for IC.
- R2: A start occurs when the last 16 bits sampled on rising `sync_clk` edges equal 0x550F, with the earliest of the 16 bits as the most significant. Other bits sent before the word do not matter. Any other 16-bit sequence leaves the block in IDLE.
- R3: IC lasts exactly ceil(`ic_ns`/`TICK_NS`) cycles and is followed by OP.
- R4: OP lasts ceil(`op_ns`/`TICK_NS`) cycles in total, counting only cycles spent in OP, and is followed by END. END persists until reset, whatever the inputs do.
- R5: With `ovl_policy`=0 (ignore), `overload` has no effect on the sequence or on the OP length.
- R6: With `ovl_policy`=1 (latch), an asserted `overload` moves OP to OVERLOAD. OVERLOAD persists until reset, even after `overload` drops.
- R7: With `halt_policy`=0 (ignore), `ext_halt` has no effect on the sequence or on the OP length.
- R8: With `halt_policy`=1 (pause), an asserted `ext_halt` moves OP to PAUSE. The block stays in PAUSE for as many cycles as `ext_halt` was held, then returns to OP. The OP timer does not advance in PAUSE.
- R9: When `overload` and `ext_halt` are both asserted in OP with `ovl_policy`=1, the block goes to OVERLOAD, not to PAUSE.
- R10: `cfg_error` is 1 when `ic_ns` or `op_ns` is below 100 or above 9,000,000,000. While it is 1, a start is ignored and the block stays in IDLE.
- R11: A change of `overload` or `ext_halt` changes the state on the third rising clock edge after the change. The policies and durations in force are those present when IDLE was left; later changes have no effect.
- R12: The state codes are IDLE=0, IC=1, OP=2, END=3, OVERLOAD=4 and PAUSE=5. `mode_ic` is 1 in IC only, `mode_op` is 1 in OP only, and `mode_halt` is 1 in every other state. Exactly one of the three is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clk | input | 1 | External sync clock; data is sampled on its rising edge |
| sync_data | input | 1 | Serial sync data line |
| ic_ns | input | 34 | Initial-condition duration in nanoseconds |
| op_ns | input | 34 | Operate duration in nanoseconds |
| ovl_policy | input | 1 | 0 = ignore overload, 1 = latch in OVERLOAD |
| halt_policy | input | 1 | 0 = ignore halt request, 1 = pause while it is held |
| overload | input | 1 | Overload flag from the analog unit |
| ext_halt | input | 1 | External halt request |
| mode_ic | output | 1 | Initial-condition mode |
| mode_op | output | 1 | Operate mode |
| mode_halt | output | 1 | Hold mode (IDLE, END, OVERLOAD, PAUSE) |
| state_code | output | 3 | Current state code |
| cfg_error | output | 1 | Duration configuration out of range |

## Verification
A wrong state register or a wrong transition shows up at once on `state_code` and on the mode outputs. A wrong phase timer shows up as an IC or OP phase that is too long or too short, or in the wrong position. The bench therefore counts the cycles of each phase to the exact cycle over a sweep of durations around multiples of the tick. A synchronizer with the wrong depth shifts the reaction to `overload` or `ext_halt` by a cycle, and the bench catches this at the third edge. A timer that keeps running in PAUSE, a policy that is not captured, or a wrong priority changes the OP cycle count or the final state of that same run.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_IC    = 3'd1,
        ST_OP    = 3'd2,
        ST_END   = 3'd3,
        ST_OVLD  = 3'd4,
        ST_PAUSE = 3'd5
    } seq_state_e;

    typedef enum logic {
        OVL_IGNORE = 1'b0,
        OVL_LATCH  = 1'b1
    } ovl_pol_e;

    typedef enum logic {
        HLT_IGNORE = 1'b0,
        HLT_PAUSE  = 1'b1
    } hlt_pol_e;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/sync_word_detect.sv
module sync_word_detect #(
    parameter int              WORD_W = 16,
    parameter logic [WORD_W-1:0] WORD = 16'h550F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sdata_s,
    output logic hit
);
    logic              sclk_prev_q;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] shift_next;
    logic              rise;

    assign rise       = sclk_s & ~sclk_prev_q;
    assign shift_next = {shift_q[WORD_W-2:0], sdata_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            shift_q     <= '0;
            hit         <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            hit         <= rise && (shift_next == WORD);
            if (rise) begin
                shift_q <= shift_next;
            end
        end
    end

    // R2: a rising edge needs a low sample before it, so a hit never repeats back to back
    assert_hit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int DUR_W   = 34,
    parameter int TICK_NS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DUR_W-1:0] duration,
    output logic             expired
);
    localparam int ACC_W = DUR_W + 1;

    logic [ACC_W-1:0] elapsed_q;
    logic [ACC_W-1:0] elapsed_inc;

    assign elapsed_inc = elapsed_q + ACC_W'(TICK_NS);
    assign expired     = elapsed_inc >= {1'b0, duration};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (clear) begin
            elapsed_q <= '0;
        end else if (run) begin
            elapsed_q <= elapsed_inc;
        end
    end

endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
    import seq_pkg::*;
#(
    parameter int                TICK_NS    = 5,
    parameter int                DUR_W      = 34,
    parameter int                SYNC_W     = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD  = 16'h550F,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DUR_W-1:0]  MIN_DUR_NS = 34'd100,
    parameter logic [DUR_W-1:0]  MAX_DUR_NS = 34'd9000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clk,
    input  logic             sync_data,
    input  logic [DUR_W-1:0] ic_ns,
    input  logic [DUR_W-1:0] op_ns,
    input  logic             ovl_policy,
    input  logic             halt_policy,
    input  logic             overload,
    input  logic             ext_halt,
    output logic             mode_ic,
    output logic             mode_op,
    output logic             mode_halt,
    output logic [2:0]       state_code,
    output logic             cfg_error
);
    localparam int NSYNC = 4;

    seq_state_e       state_q, state_d;
    logic [NSYNC-1:0] raw_in, synced;
    logic             sclk_s, sdata_s, ovl_s, hlt_s;
    logic             start_hit;
    logic             cfg_bad;
    logic             leave_idle;
    logic             tmr_clear, tmr_run, tmr_done;
    logic [DUR_W-1:0] ic_dur_q, op_dur_q, tmr_dur;
    ovl_pol_e         ovl_pol_q;
    hlt_pol_e         hlt_pol_q;

    // Resample every asynchronous input
    assign raw_in = {sync_clk, sync_data, overload, ext_halt};

    bit_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (synced)
    );

    assign {sclk_s, sdata_s, ovl_s, hlt_s} = synced;

    sync_word_detect #(.WORD_W(SYNC_W), .WORD(SYNC_WORD)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .hit     (start_hit)
    );

    // Duration range check
    always_comb begin
        cfg_bad = (ic_ns < MIN_DUR_NS) || (ic_ns > MAX_DUR_NS) ||
                  (op_ns < MIN_DUR_NS) || (op_ns > MAX_DUR_NS);
    end
    assign cfg_error = cfg_bad;

    assign leave_idle = (state_q == ST_IDLE) && start_hit && !cfg_bad;

    // Configuration captured on the way out of IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_dur_q  <= '0;
            op_dur_q  <= '0;
            ovl_pol_q <= OVL_IGNORE;
            hlt_pol_q <= HLT_IGNORE;
        end else if (leave_idle) begin
            ic_dur_q  <= ic_ns;
            op_dur_q  <= op_ns;
            ovl_pol_q <= ovl_pol_e'(ovl_policy);
            hlt_pol_q <= hlt_pol_e'(halt_policy);
        end
    end

    // Phase timer shared by IC and OP
    assign tmr_dur   = (state_q == ST_IC) ? ic_dur_q : op_dur_q;
    assign tmr_run   = (state_q == ST_IC) || (state_q == ST_OP);
    assign tmr_clear = leave_idle || ((state_q == ST_IC) && tmr_done);

    phase_timer #(.DUR_W(DUR_W), .TICK_NS(TICK_NS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .run      (tmr_run),
        .duration (tmr_dur),
        .expired  (tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (leave_idle) state_d = ST_IC;
            end
            ST_IC: begin
                if (tmr_done) state_d = ST_OP;
            end
            ST_OP: begin
                if (ovl_pol_q == OVL_LATCH && ovl_s) begin
                    state_d = ST_OVLD;
                end else if (hlt_pol_q == HLT_PAUSE && hlt_s) begin
                    state_d = ST_PAUSE;
                end else if (tmr_done) begin
                    state_d = ST_END;
                end
            end
            ST_PAUSE: begin
                if (!hlt_s) state_d = ST_OP;
            end
            ST_END:  state_d = ST_END;
            ST_OVLD: state_d = ST_OVLD;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        mode_ic    = 1'b0;
        mode_op    = 1'b0;
        mode_halt  = 1'b0;
        state_code = state_q;
        unique case (state_q)
            ST_IC:   mode_ic   = 1'b1;
            ST_OP:   mode_op   = 1'b1;
            default: mode_halt = 1'b1;
        endcase
    end

    // Checks on the sequence
    assert_idle_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_IC));

    assert_end_absorbs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |=> (state_q == ST_END));

    assert_ignore_ovl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP && ovl_pol_q == OVL_IGNORE) |=> (state_q != ST_OVLD));

    assert_ovld_absorbs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVLD) |=> (state_q == ST_OVLD));

    assert_ignore_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP && hlt_pol_q == HLT_IGNORE) |=> (state_q != ST_PAUSE));

    assert_pause_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |=> (state_q == ST_PAUSE || state_q == ST_OP));

    assert_ovl_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP && ovl_pol_q == OVL_LATCH && ovl_s) |=> (state_q == ST_OVLD));

    assert_cfg_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cfg_error) |=> (state_q == ST_IDLE));

    assert_modes_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_ic, mode_op, mode_halt}) == 1);

endmodule

// File: tb/run_sequencer_bench.sv
`timescale 1ns/1ps
module run_sequencer_bench;

    localparam int TICK = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_clk = 1'b0;
    logic        sync_data = 1'b0;
    logic [33:0] ic_ns = 34'd100;
    logic [33:0] op_ns = 34'd100;
    logic        ovl_policy = 1'b0;
    logic        halt_policy = 1'b0;
    logic        overload = 1'b0;
    logic        ext_halt = 1'b0;
    logic        mode_ic, mode_op, mode_halt, cfg_error;
    logic [2:0]  state_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    run_sequencer #(.TICK_NS(TICK)) u_run_sequencer (
        .clk(clk), .rst_n(rst_n), .sync_clk(sync_clk), .sync_data(sync_data),
        .ic_ns(ic_ns), .op_ns(op_ns), .ovl_policy(ovl_policy), .halt_policy(halt_policy),
        .overload(overload), .ext_halt(ext_halt), .mode_ic(mode_ic), .mode_op(mode_op),
        .mode_halt(mode_halt), .state_code(state_code), .cfg_error(cfg_error)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint cycles_for(input longint d);
        return (d + TICK - 1) / TICK;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; overload = 1'b0; ext_halt = 1'b0;
        sync_clk = 1'b0; sync_data = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) begin
            sync_data = w[b];
            repeat (3) @(negedge clk);
            sync_clk = 1'b1;
            repeat (3) @(negedge clk);
            sync_clk = 1'b0;
        end
    endtask

    task automatic wait_state(input int code, input int limit, output bit ok);
        ok = 0;
        for (int i = 0; i < limit; i++) begin
            if (state_code == code) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic count_state(input int code, output int n);
        n = 0;
        while (state_code == code && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Walk through OP/PAUSE, driving overload and halt at given OP-relative cycles
    task automatic run_op(input int ovl_at, input int h_on, input int h_off,
                          output int op_n, output int pause_n, output int fin);
        op_n = 0; pause_n = 0;
        for (int i = 0; i < 5000; i++) begin
            if (state_code != 3'd2 && state_code != 3'd5) break;
            if (state_code == 3'd2) op_n++;
            if (state_code == 3'd5) pause_n++;
            if (i == ovl_at) overload = 1'b1;
            if (i == h_on)   ext_halt = 1'b1;
            if (i == h_off)  ext_halt = 1'b0;
            @(negedge clk);
        end
        fin = state_code;
    endtask

    task automatic start_run(input longint ic, input longint op, input bit op_pol, input bit hp);
        bit ok;
        ic_ns = 34'(ic); op_ns = 34'(op);
        ovl_policy = op_pol; halt_policy = hp;
        do_reset();
        send_word(16'h550F);
        wait_state(1, 40, ok);
        chk("R2 start after sync word", ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint ic_tab[4] = '{100, 101, 104, 343};
        longint op_tab[3] = '{100, 126, 250};
        int n, op_n, pause_n, fin;
        bit ok;

        // R1 / R12 reset state
        do_reset();
        chk("R1 reset state code", state_code, 0);
        chk("R1 reset mode_halt", mode_halt, 1);
        chk("R12 reset mode_ic/op", {mode_ic, mode_op}, 0);
        chk("R10 valid config no error", cfg_error, 0);

        // R2 wrong word keeps IDLE
        send_word(16'h550E);
        repeat (30) @(negedge clk);
        chk("R2 wrong word stays idle", state_code, 0);
        // R2 junk bits then the word
        send_word(16'hA3C1);
        send_word(16'h550F);
        wait_state(1, 40, ok);
        chk("R2 word after junk starts", ok, 1);
        chk("R12 IC mode outputs", {mode_ic, mode_op, mode_halt}, 3'b100);

        // R3 / R4 sweep of durations
        foreach (ic_tab[a]) begin
            foreach (op_tab[b]) begin
                start_run(ic_tab[a], op_tab[b], 1'b0, 1'b0);
                count_state(1, n);
                chk("R3 IC cycle count", n, cycles_for(ic_tab[a]));
                chk("R12 OP mode outputs", {mode_ic, mode_op, mode_halt}, 3'b010);
                count_state(2, n);
                chk("R4 OP cycle count", n, cycles_for(op_tab[b]));
                chk("R4 reaches END", state_code, 3);
            end
        end

        // R4 END absorbs inputs
        overload = 1'b1; ext_halt = 1'b1; ovl_policy = 1'b1; halt_policy = 1'b1;
        send_word(16'h550F);
        repeat (10) @(negedge clk);
        chk("R4 END persists", state_code, 3);

        // R6 / R11 overload latching with synchronizer latency
        start_run(100, 500, 1'b1, 1'b0);
        count_state(1, n);
        repeat (4) @(negedge clk);
        overload = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 overload not seen before third edge", state_code, 2);
        @(negedge clk);
        chk("R6 overload enters OVERLOAD", state_code, 4);
        overload = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 OVERLOAD persists", state_code, 4);
        chk("R12 OVERLOAD mode_halt", mode_halt, 1);

        // R5 overload ignored
        start_run(100, 300, 1'b0, 1'b0);
        count_state(1, n);
        run_op(5, -1, -1, op_n, pause_n, fin);
        chk("R5 OP length unchanged", op_n, cycles_for(300));
        chk("R5 final END", fin, 3);

        // R8 pause freezes OP timer
        start_run(100, 300, 1'b0, 1'b1);
        count_state(1, n);
        run_op(-1, 10, 17, op_n, pause_n, fin);
        chk("R8 PAUSE length", pause_n, 7);
        chk("R8 OP length excludes pause", op_n, cycles_for(300));
        chk("R8 final END", fin, 3);

        // R7 halt ignored
        start_run(100, 300, 1'b0, 1'b0);
        count_state(1, n);
        run_op(-1, 10, 17, op_n, pause_n, fin);
        chk("R7 no PAUSE", pause_n, 0);
        chk("R7 OP length unchanged", op_n, cycles_for(300));

        // R9 overload wins over halt
        start_run(100, 300, 1'b1, 1'b1);
        count_state(1, n);
        run_op(5, 5, -1, op_n, pause_n, fin);
        chk("R9 final OVERLOAD", fin, 4);
        chk("R9 no PAUSE", pause_n, 0);
        chk("R11 overload reaction cycle", op_n, 8);

        // R11 configuration captured when leaving IDLE
        start_run(100, 200, 1'b0, 1'b0);
        ovl_policy = 1'b1; op_ns = 34'd1000;
        count_state(1, n);
        run_op(3, -1, -1, op_n, pause_n, fin);
        chk("R11 policy change ignored", fin, 3);
        chk("R11 duration change ignored", op_n, cycles_for(200));

        // R10 range errors
        ic_ns = 34'd99; op_ns = 34'd500;
        do_reset();
        chk("R10 short IC flags error", cfg_error, 1);
        send_word(16'h550F);
        repeat (30) @(negedge clk);
        chk("R10 start blocked", state_code, 0);
        ic_ns = 34'd100; op_ns = 34'd9000000001;
        @(negedge clk);
        chk("R10 long OP flags error", cfg_error, 1);
        op_ns = 34'd9000000000;
        @(negedge clk);
        chk("R10 upper limit accepted", cfg_error, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule